// File: doc/BRIEF.md
# Processor Interrupt Exception Entry Unit

This block is the exception-entry part of a small 32-bit processor core. At every instruction boundary it looks at two level-sensitive request lines: a normal interrupt and a fast interrupt. The fast interrupt has priority. When a request is accepted, the block rewrites the status word and produces the vector the fetch unit must jump to. For a normal interrupt it also saves the return address and the old status word in its own bank. A return strobe reverses a normal-interrupt entry. It reloads the program counter and the status word from that bank in a single step.

The core gives the block the next-instruction address, the live status word and a high-vectors configuration bit. It takes `pc_o` and `status_o` whenever `redirect_o` pulses. `entry_o` marks the cycles in which a vector was actually taken. The register file and the instruction decode sit outside this block. The reset input is asserted asynchronously and is released through an internal two-stage synchronizer.

Top module: `exc_entry_unit`

## Requirements
- R1: A normal interrupt is accepted only in a cycle with `boundary_i`=1, `irq_req_i`=1, `ret_i`=0 and status bit 7 (interrupt mask) clear. In any other case it is not taken.
- R2: If `boundary_i`=1, `ret_i`=0, `fiq_req_i`=1 and status bit 6 (fast mask) is clear, the fast entry is performed, even when a normal interrupt is also eligible. The fast entry sets status[4:0]=0x11, sets bits 7 and 6, clears bit 5 and keeps bits [31:8]. It sets the PC to the vector base + 0x1C and leaves the link and saved-status registers unchanged.
- R3: On a normal entry, status[4:0] becomes 0x12, bit 5 (state) is cleared, bit 6 keeps its old value, bit 7 is set and bits [31:8] are kept.
- R4: On a normal entry, the link register receives the next-instruction address plus 4, and the saved-status register receives the whole incoming status word.
- R5: The vector base is 0xFFFF0000 when `hivec_i`=1 and 0x00000000 otherwise. A normal entry jumps to base + 0x18.
- R6: When `ret_i`=1, the PC becomes link − 4 and the status becomes the saved status, in the same cycle. A return overrides any boundary request in that cycle and leaves link and saved status unchanged.
- R7: `entry_o` is high for exactly the one cycle after each taken entry. `redirect_o` is high for the one cycle after each entry or return.
- R8: In a cycle with no entry and no return, `pc_o`, `status_o`, `link_o` and `saved_status_o` hold their values, and both pulses are low.
- R9: After reset, `pc_o`=0, `status_o`=0x000000D3 (supervisor mode, both masks set), `link_o`=0, `saved_status_o`=0, and both pulses are low.
- R10: With status bit 6 set, a pending fast request is ignored, and an eligible normal interrupt at the same boundary is taken instead.
- Outputs are registered and appear one clock after the sampled inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| irq_req_i | input | 1 | Normal interrupt request, level |
| fiq_req_i | input | 1 | Fast interrupt request, level |
| boundary_i | input | 1 | Instruction-boundary strobe |
| next_addr_i | input | 32 | Address of the next instruction to execute |
| status_i | input | 32 | Current status word |
| hivec_i | input | 1 | Selects the high vector base |
| ret_i | input | 1 | Return-from-interrupt strobe |
| pc_o | output | 32 | New program counter |
| status_o | output | 32 | New status word |
| saved_status_o | output | 32 | Saved status of the normal-interrupt bank |
| link_o | output | 32 | Banked link register |
| entry_o | output | 1 | One-cycle pulse for each taken vector |
| redirect_o | output | 1 | One-cycle pulse when pc_o/status_o carry a new value |

## Verification
The bench presents both requests at the same boundary, with each mask set and clear in turn. A design with inverted priority would enter mode 0x12 where 0x11 is expected. A design that ignores the fast mask would never fall back to the normal entry. The bench also checks that bit 6 survives a normal entry and that bits [31:8] are never touched. A rewrite that forces bit 6 or clears the upper bits shows up as a wrong status. A return asserted on a boundary with requests pending must restore the bank and must not vector. Mixing up the +4 on entry with the −4 on return, or letting a fast entry overwrite the bank, produces a wrong address on the next return.

// File: rtl/exc_pkg.sv
package exc_pkg;

  typedef enum logic [1:0] {
    EV_NONE = 2'd0,
    EV_IRQ  = 2'd1,
    EV_FIQ  = 2'd2,
    EV_RET  = 2'd3
  } exc_event_e;

  localparam int MODE_W = 5;
  localparam int BIT_T  = 5;
  localparam int BIT_F  = 6;
  localparam int BIT_I  = 7;

  localparam logic [MODE_W-1:0] MODE_USR = 5'h10;
  localparam logic [MODE_W-1:0] MODE_FIQ = 5'h11;
  localparam logic [MODE_W-1:0] MODE_IRQ = 5'h12;
  localparam logic [MODE_W-1:0] MODE_SVC = 5'h13;
  localparam logic [MODE_W-1:0] MODE_ABT = 5'h17;
  localparam logic [MODE_W-1:0] MODE_UND = 5'h1B;
  localparam logic [MODE_W-1:0] MODE_SYS = 5'h1F;

endpackage

// File: rtl/exc_arbiter.sv
module exc_arbiter
  import exc_pkg::*;
(
  input  logic       ret_i,
  input  logic       boundary_i,
  input  logic       irq_req_i,
  input  logic       fiq_req_i,
  input  logic       irq_mask_i,
  input  logic       fiq_mask_i,
  output exc_event_e event_o
);

  logic fiq_ok;
  logic irq_ok;

  assign fiq_ok = boundary_i && fiq_req_i && !fiq_mask_i;
  assign irq_ok = boundary_i && irq_req_i && !irq_mask_i;

  always_comb begin
    event_o = EV_NONE;
    if (ret_i) begin
      event_o = EV_RET;
    end else if (fiq_ok) begin
      event_o = EV_FIQ;
    end else if (irq_ok) begin
      event_o = EV_IRQ;
    end
  end

endmodule

// File: rtl/exc_status_xform.sv
module exc_status_xform
  import exc_pkg::*;
#(
  parameter int SW = 32
) (
  input  logic [SW-1:0] status_i,
  input  exc_event_e    event_i,
  output logic [SW-1:0] status_o
);

  always_comb begin
    status_o = status_i;
    unique case (event_i)
      EV_IRQ: begin
        status_o[MODE_W-1:0] = MODE_IRQ;
        status_o[BIT_T]      = 1'b0;
        status_o[BIT_I]      = 1'b1;
      end
      EV_FIQ: begin
        status_o[MODE_W-1:0] = MODE_FIQ;
        status_o[BIT_T]      = 1'b0;
        status_o[BIT_F]      = 1'b1;
        status_o[BIT_I]      = 1'b1;
      end
      default: status_o = status_i;
    endcase
  end

endmodule

// File: rtl/exc_vector_sel.sv
module exc_vector_sel #(
  parameter int          XLEN     = 32,
  parameter logic [31:0] VEC_LO   = 32'h0000_0000,
  parameter logic [31:0] VEC_HI   = 32'hFFFF_0000,
  parameter logic [31:0] IRQ_OFS  = 32'h18,
  parameter logic [31:0] FIQ_OFS  = 32'h1C,
  parameter bit          HIVEC_EN = 1'b1
) (
  input  logic            hivec_i,
  input  logic            is_fiq_i,
  output logic [XLEN-1:0] vector_o
);

  logic [XLEN-1:0] base;
  logic [XLEN-1:0] ofs;

  generate
    if (HIVEC_EN) begin : g_hivec
      assign base = hivec_i ? VEC_HI[XLEN-1:0] : VEC_LO[XLEN-1:0];
    end else begin : g_lovec
      logic unused_hv;
      assign unused_hv = hivec_i;
      assign base      = VEC_LO[XLEN-1:0];
    end
  endgenerate

  assign ofs      = is_fiq_i ? FIQ_OFS[XLEN-1:0] : IRQ_OFS[XLEN-1:0];
  assign vector_o = base + ofs;

endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
  import exc_pkg::*;
#(
  parameter int          XLEN       = 32,
  parameter logic [31:0] VEC_LO     = 32'h0000_0000,
  parameter logic [31:0] VEC_HI     = 32'hFFFF_0000,
  parameter logic [31:0] IRQ_OFS    = 32'h18,
  parameter logic [31:0] FIQ_OFS    = 32'h1C,
  parameter logic [31:0] LINK_ADJ   = 32'h4,
  parameter logic [31:0] RET_ADJ    = 32'h4,
  parameter logic [31:0] RST_STATUS = 32'h0000_00D3,
  parameter bit          HIVEC_EN   = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            irq_req_i,
  input  logic            fiq_req_i,
  input  logic            boundary_i,
  input  logic [XLEN-1:0] next_addr_i,
  input  logic [XLEN-1:0] status_i,
  input  logic            hivec_i,
  input  logic            ret_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] status_o,
  output logic [XLEN-1:0] saved_status_o,
  output logic [XLEN-1:0] link_o,
  output logic            entry_o,
  output logic            redirect_o
);

  localparam logic [XLEN-1:0] LINK_ADJ_W = LINK_ADJ[XLEN-1:0];
  localparam logic [XLEN-1:0] RET_ADJ_W  = RET_ADJ[XLEN-1:0];
  localparam logic [XLEN-1:0] RST_ST_W   = RST_STATUS[XLEN-1:0];

  // reset synchronizer: assert asynchronously, release on the clock
  logic rst_meta_n;
  logic rst_q_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_n <= 1'b0;
      rst_q_n    <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_q_n    <= rst_meta_n;
    end
  end

  // event selection and field rewrites
  exc_event_e      ev;
  logic [XLEN-1:0] st_entry;
  logic [XLEN-1:0] vector;

  exc_arbiter u_arb (
    .ret_i      (ret_i),
    .boundary_i (boundary_i),
    .irq_req_i  (irq_req_i),
    .fiq_req_i  (fiq_req_i),
    .irq_mask_i (status_i[BIT_I]),
    .fiq_mask_i (status_i[BIT_F]),
    .event_o    (ev)
  );

  exc_status_xform #(.SW(XLEN)) u_xform (
    .status_i (status_i),
    .event_i  (ev),
    .status_o (st_entry)
  );

  exc_vector_sel #(
    .XLEN     (XLEN),
    .VEC_LO   (VEC_LO),
    .VEC_HI   (VEC_HI),
    .IRQ_OFS  (IRQ_OFS),
    .FIQ_OFS  (FIQ_OFS),
    .HIVEC_EN (HIVEC_EN)
  ) u_vec (
    .hivec_i  (hivec_i),
    .is_fiq_i (ev == EV_FIQ),
    .vector_o (vector)
  );

  // next-state logic
  logic [XLEN-1:0] pc_d, st_d, link_d, saved_d;
  logic            pc_en, bank_en;
  logic            entry_d, redirect_d;

  always_comb begin
    pc_d       = pc_o;
    st_d       = status_o;
    link_d     = link_o;
    saved_d    = saved_status_o;
    pc_en      = 1'b0;
    bank_en    = 1'b0;
    entry_d    = 1'b0;
    redirect_d = 1'b0;
    unique case (ev)
      EV_RET: begin
        pc_d       = link_o - RET_ADJ_W;
        st_d       = saved_status_o;
        pc_en      = 1'b1;
        redirect_d = 1'b1;
      end
      EV_FIQ: begin
        pc_d       = vector;
        st_d       = st_entry;
        pc_en      = 1'b1;
        entry_d    = 1'b1;
        redirect_d = 1'b1;
      end
      EV_IRQ: begin
        pc_d       = vector;
        st_d       = st_entry;
        link_d     = next_addr_i + LINK_ADJ_W;
        saved_d    = status_i;
        pc_en      = 1'b1;
        bank_en    = 1'b1;
        entry_d    = 1'b1;
        redirect_d = 1'b1;
      end
      default: ;
    endcase
  end

  // registers
  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      pc_o       <= '0;
      status_o   <= RST_ST_W;
      entry_o    <= 1'b0;
      redirect_o <= 1'b0;
    end else begin
      entry_o    <= entry_d;
      redirect_o <= redirect_d;
      if (pc_en) begin
        pc_o     <= pc_d;
        status_o <= st_d;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_q_n) begin
    if (!rst_q_n) begin
      link_o         <= '0;
      saved_status_o <= '0;
    end else if (bank_en) begin
      link_o         <= link_d;
      saved_status_o <= saved_d;
    end
  end

  // assertions
  AST_IRQ_ONLY_WHEN_OPEN: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (entry_o && status_o[MODE_W-1:0] == MODE_IRQ) |->
      $past(boundary_i && irq_req_i && !status_i[BIT_I] && !ret_i)); // R1

  AST_FIQ_WINS: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(boundary_i && fiq_req_i && !status_i[BIT_F] && !ret_i)) |->
      (entry_o && status_o[MODE_W-1:0] == MODE_FIQ && $stable(link_o))); // R2

  AST_IRQ_FIELDS: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (entry_o && status_o[MODE_W-1:0] == MODE_IRQ) |->
      (status_o[BIT_I] && !status_o[BIT_T] && status_o[BIT_F] == $past(status_i[BIT_F])
       && status_o[XLEN-1:8] == $past(status_i[XLEN-1:8]))); // R3

  AST_IRQ_BANK: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (entry_o && status_o[MODE_W-1:0] == MODE_IRQ) |->
      (link_o == $past(next_addr_i) + LINK_ADJ_W && saved_status_o == $past(status_i))); // R4

  AST_IRQ_VECTOR: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    (entry_o && status_o[MODE_W-1:0] == MODE_IRQ) |->
      (pc_o == (($past(hivec_i) && HIVEC_EN) ? VEC_HI[XLEN-1:0] : VEC_LO[XLEN-1:0])
               + IRQ_OFS[XLEN-1:0])); // R5

  AST_RETURN_RESTORE: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ($past(rst_q_n) && $past(ret_i)) |->
      (pc_o == $past(link_o) - RET_ADJ_W && status_o == $past(saved_status_o)
       && !entry_o && redirect_o)); // R6

  AST_QUIET_HOLD: assert property (@(posedge clk_i) disable iff (!rst_q_n)
    ($past(rst_q_n) && !redirect_o) |->
      ($stable(pc_o) && $stable(status_o) && $stable(link_o) && !entry_o)); // R8

endmodule

// File: tb/sim_exc_entry_unit.sv
module sim_exc_entry_unit;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq, fiq, bnd, hv, ret;
  logic [31:0] addr, st;
  logic [31:0] pc_o, status_o, saved_o, link_o;
  logic        entry_o, redirect_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  logic [31:0] m_pc, m_st, m_link, m_sv;

  always #2 clk = ~clk;  // 250 MHz

  exc_entry_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .irq_req_i(irq), .fiq_req_i(fiq),
    .boundary_i(bnd), .next_addr_i(addr), .status_i(st), .hivec_i(hv),
    .ret_i(ret), .pc_o(pc_o), .status_o(status_o), .saved_status_o(saved_o),
    .link_o(link_o), .entry_o(entry_o), .redirect_o(redirect_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] vec_of(input logic h, input logic f);
    return (h ? 32'hFFFF_0000 : 32'h0) + (f ? 32'h1C : 32'h18);
  endfunction

  // 0 none, 1 irq, 2 fiq, 3 ret
  function automatic int pick(input logic i, input logic f, input logic b,
                              input logic [31:0] s, input logic r);
    if (r) return 3;
    if (b && f && !s[6]) return 2;
    if (b && i && !s[7]) return 1;
    return 0;
  endfunction

  task automatic step(input logic i, input logic f, input logic b, input logic [31:0] a,
                      input logic [31:0] s, input logic h, input logic r);
    int ev;
    logic [31:0] e_pc, e_st, e_link, e_sv;
    irq = i; fiq = f; bnd = b; addr = a; st = s; hv = h; ret = r;
    ev = pick(i, f, b, s, r);
    e_pc = m_pc; e_st = m_st; e_link = m_link; e_sv = m_sv;
    case (ev)
      3: begin e_pc = m_link - 32'd4; e_st = m_sv; end
      2: begin e_pc = vec_of(h, 1'b1); e_st = {s[31:8], 3'b110, 5'h11}; end
      1: begin
        e_pc = vec_of(h, 1'b0); e_st = {s[31:8], 1'b1, s[6], 1'b0, 5'h12};
        e_link = a + 32'd4; e_sv = s;
      end
      default: ;
    endcase
    @(posedge clk); #1;
    case (ev)
      3: begin chk("R6 pc", pc_o, e_pc); chk("R6 status", status_o, e_st);
               chk("R6 link", link_o, e_link); chk("R6 saved", saved_o, e_sv); end
      2: begin chk("R2 pc", pc_o, e_pc); chk("R2 status", status_o, e_st);
               chk("R2 link", link_o, e_link); chk("R2 saved", saved_o, e_sv); end
      1: begin chk("R5 pc", pc_o, e_pc); chk("R3 status", status_o, e_st);
               chk("R4 link", link_o, e_link); chk("R4 saved", saved_o, e_sv); end
      default: begin chk("R8 pc", pc_o, e_pc); chk("R8 status", status_o, e_st);
               chk("R8 link", link_o, e_link); chk("R8 saved", saved_o, e_sv); end
    endcase
    chk("R7 entry", {31'd0, entry_o}, {31'd0, ev == 1 || ev == 2});
    chk("R7 redirect", {31'd0, redirect_o}, {31'd0, ev != 0});
    m_pc = e_pc; m_st = e_st; m_link = e_link; m_sv = e_sv;
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(4 * 20000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      report();
    end
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_1234);
    rst_n = 1'b0; irq = 0; fiq = 0; bnd = 0; hv = 0; ret = 0; addr = '0; st = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    // R9 reset state
    chk("R9 pc", pc_o, 32'h0);
    chk("R9 status", status_o, 32'h0000_00D3);
    chk("R9 link", link_o, 32'h0);
    chk("R9 saved", saved_o, 32'h0);
    chk("R9 pulses", {30'd0, entry_o, redirect_o}, 32'h0);
    m_pc = 0; m_st = 32'hD3; m_link = 0; m_sv = 0;

    // R1: masked, no boundary
    step(1, 0, 1, 32'h100, 32'h0000_0090, 0, 0);
    chk("R1 masked no entry", {31'd0, entry_o}, 32'h0);
    step(1, 0, 0, 32'h104, 32'h0000_0010, 0, 0);
    chk("R1 no boundary", {31'd0, entry_o}, 32'h0);
    // normal entry low vectors, bit 6 set kept
    step(1, 0, 1, 32'h0000_2000, 32'hA000_0070, 0, 0);
    chk("R5 low vector", pc_o, 32'h18);
    // return restores
    step(0, 0, 0, 32'h0, 32'h0, 0, 1);
    chk("R6 ret pc", pc_o, 32'h2000);
    // high vectors, bit 6 clear kept
    step(1, 0, 1, 32'h0000_3000, 32'h5000_0010, 1, 0);
    chk("R5 high vector", pc_o, 32'hFFFF_0018);
    // both pending, F clear -> fast
    step(1, 1, 1, 32'h0000_4000, 32'h0000_001F, 0, 0);
    chk("R2 mode", {27'd0, status_o[4:0]}, 32'h11);
    // both pending, F set -> normal
    step(1, 1, 1, 32'h0000_5000, 32'h0000_005F, 1, 0);
    chk("R10 mode", {27'd0, status_o[4:0]}, 32'h12);
    // return beats a boundary request
    step(1, 1, 1, 32'h0000_6000, 32'h0000_0010, 0, 1);
    chk("R6 ret wins", pc_o, 32'h5000);
    // back-to-back entries
    step(1, 0, 1, 32'h0000_7000, 32'h0000_0013, 0, 0);
    step(1, 0, 1, 32'h0000_7100, 32'h0000_0013, 0, 0);
    chk("R7 second pulse", {31'd0, entry_o}, 32'h1);
    step(0, 0, 0, 32'h0, 32'h0, 0, 0);

    for (int k = 0; k < 400; k++) begin
      logic [31:0] s;
      s = $urandom;
      step($urandom_range(0, 1), $urandom_range(0, 3) == 0, $urandom_range(0, 3) != 0,
           $urandom & 32'hFFFF_FFFC, s, $urandom_range(0, 1), $urandom_range(0, 5) == 0);
    end
    done = 1'b1;
    report();
  end

endmodule